// File: doc/BRIEF.md
# Serial HDLC Frame Transmitter with Abort

This block turns a stream of bytes into a bit-serial HDLC line signal. Between frames it keeps the line busy with back-to-back flag octets. When a byte is waiting at a flag boundary, the flag just sent becomes the opening flag. The bytes of the frame then go out least-significant bit first. A zero is inserted after every run of five ones in the frame contents. A 16-bit frame check sequence (FCS) is normally appended, and a closing flag ends the frame. The frame ends after the byte that carries the end-of-packet marker.

Bytes arrive on a valid/ready interface. One output bit is produced on each clock cycle where the bit-enable input is high, and the surrounding line framer drives that enable. A control input suppresses the FCS for terminal adaptation, so the closing flag follows the last data byte directly.

A frame can be cut short in two ways. An abort request stops the frame at the next bit slot and sends a run of ones. If the next byte is not available when it is needed, the block aborts on its own and raises an underrun pulse. Either way, flag idling resumes afterwards.

Top module: `hdlc_frame_tx`

## Requirements
- R1: After reset `tx_bit` is 1, `in_ready` is 0 and `underrun` is 0. With no frame pending, the line repeats the flag octet 0x7E, sent LSB first as 0,1,1,1,1,1,1,0.
- R2: A frame starts at a flag boundary while `in_valid` is high; the flag just completed is the opening flag. Each accepted byte is sent LSB first, and a closing flag follows the frame.
- R3: After five consecutive ones among frame bits (data and FCS), one 0 is inserted. The count of ones restarts after the inserted 0. No zero is inserted inside flags or abort runs.
- R4: The FCS uses generator x^16+x^12+x^5+1 and is preset to 0xFFFF over the data bits in transmit order. The ones-complement of the remainder is sent low byte first, each byte LSB first. A receiver running the same register over data plus FCS ends with 0xF0B8.
- R5: When `fcs_inhibit` is high as the last data bit leaves, no FCS is sent and the closing flag follows that bit (after any inserted zero).
- R6: The byte accepted with `in_last` high is the last data byte of its frame. `in_ready` stays low for the rest of that frame.
- R7: An `abort_req` pulse during data or FCS ends the frame at the next enabled bit. The block sends eight consecutive ones, then returns to flag idling.
- R8: An `abort_req` pulse while idling with flags has no effect: the flag stream continues and no abort run appears.
- R9: If no byte is valid when the next data byte of an unfinished frame is needed, the block sends an abort run of eight ones. It also raises `underrun` for exactly one clock cycle.
- R10: `tx_bit` changes only on a clock edge where `bit_en` is high. `in_ready` is high only while `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One output bit is produced per cycle with this high |
| fcs_inhibit | input | 1 | Suppresses the FCS of the current frame |
| abort_req | input | 1 | Pulse to abandon the frame in progress |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | The byte is the last one of its frame |
| in_ready | output | 1 | Byte accepted on this edge when `in_valid` is high |
| tx_bit | output | 1 | Serial line output |
| underrun | output | 1 | One-cycle pulse when a frame is aborted for lack of data |

## Verification
Frames of plain counting bytes check byte order and the FCS. Frames made of 0xFF and 0x7E patterns force zero insertion in the middle of a byte, across byte edges and just before the closing flag. The bench decodes the line on its own, so misplaced or missing stuffing shows up as corrupted bytes or false flags. Single-byte frames, a frame with FCS inhibited, and bit enables at full and one-third rate separate the end-of-packet and inhibit paths from the enable gating. Aborts during data, during the FCS, while idle, and caused by an underrun each show whether the abort run is sent and whether the underrun pulse appears, and no other outcome.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the serial HDLC transmitter.
// Assumes bits go out LSB first, so the CRC register runs in reflected form.
package hdlc_tx_pkg;
    typedef enum logic [1:0] {
        ST_FLAG  = 2'd0,
        ST_DATA  = 2'd1,
        ST_FCS   = 2'd2,
        ST_ABORT = 2'd3
    } tx_state_e;

    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;  // x^16+x^12+x^5+1, reflected
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
endpackage

// File: rtl/hdlc_tx_crc.sv
`timescale 1ns/1ps
// Module: bit-serial CRC register for the frame check sequence.
// Assumes data bits enter in line order (LSB first), which means a
// right-shifting register with the reflected polynomial. crc_upd is the
// value the register takes if the current bit is stepped in.
module hdlc_tx_crc #(
    parameter int          CRC_W  = 16,
    parameter logic [15:0] POLY   = 16'h8408,
    parameter logic [15:0] PRESET = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             step,
    input  logic             din,
    output logic [CRC_W-1:0] crc_upd
);
    logic [CRC_W-1:0] crc_q;
    logic             fb;

    // Next register value if din is shifted in.
    always_comb begin
        fb      = crc_q[0] ^ din;
        crc_upd = {1'b0, crc_q[CRC_W-1:1]} ^ (fb ? POLY[CRC_W-1:0] : '0);
    end

    // Register: preset at frame start, advance on each data bit.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= PRESET[CRC_W-1:0];
        else if (init) crc_q <= PRESET[CRC_W-1:0];
        else if (step) crc_q <= crc_upd;
    end
endmodule

// File: rtl/hdlc_tx_zero_ins.sv
`timescale 1ns/1ps
// Module: run-of-ones tracker for zero insertion.
// Counts consecutive ones among frame bits and raises stuff_due once
// RUN_LEN ones have gone out. Any enabled bit that is not a frame bit
// (flag, abort or the inserted zero itself) clears the count.
module hdlc_tx_zero_ins #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_bit,
    input  logic bit_val,
    input  logic clr,
    output logic stuff_due
);
    localparam int CW = $clog2(RUN_LEN + 1);
    logic [CW-1:0] run_q;

    // Run counter: count frame ones, reset on zeros and non-frame bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (clr)       run_q <= '0;
        else if (frame_bit) run_q <= bit_val ? run_q + CW'(1) : '0;
    end

    // Insert-due flag when the run reaches its limit.
    assign stuff_due = (run_q == CW'(RUN_LEN));
endmodule

// File: rtl/hdlc_frame_tx.sv
`timescale 1ns/1ps
// Module: serial HDLC frame transmitter (top).
// Idles with flags. Starts a frame at a flag boundary when a byte is valid,
// sends bytes LSB first with zero insertion, appends the FCS unless it is
// inhibited, and closes with a flag. An abort request or a data underrun
// ends the frame with ABORT_LEN ones. One bit goes out per cycle with bit_en.
// Assumes fcs_inhibit is steady while a frame's last byte is sent.
module hdlc_frame_tx
    import hdlc_tx_pkg::*;
#(
    parameter int RUN_LEN   = 5,
    parameter int ABORT_LEN = 8,
    parameter int CRC_W     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       fcs_inhibit,
    input  logic       abort_req,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic       tx_bit,
    output logic       underrun
);
    localparam int BYTE_W  = 8;
    localparam int CNT_MAX = (CRC_W > ABORT_LEN) ? CRC_W : ABORT_LEN;
    localparam int IDX_W   = $clog2(CNT_MAX);

    tx_state_e        st_q;
    logic [IDX_W-1:0] idx_q;
    logic [CRC_W-1:0] shreg_q;
    logic             last_q;
    logic             abort_pend_q;

    logic             in_frame, abort_now, stuff_now, sent_frame_bit;
    logic             byte_end, take, cur_bit, stuff_due;
    logic [CRC_W-1:0] crc_upd;

    // Slot decode: abort beats zero insertion, which beats a normal bit.
    always_comb begin
        in_frame       = (st_q == ST_DATA) || (st_q == ST_FCS);
        abort_now      = bit_en && in_frame && (abort_pend_q || abort_req);
        stuff_now      = bit_en && stuff_due && (st_q != ST_ABORT) && !abort_now;
        sent_frame_bit = bit_en && in_frame && !abort_now && !stuff_now;
        byte_end       = (idx_q == IDX_W'(BYTE_W - 1));
        in_ready       = bit_en && !abort_now && !stuff_now && byte_end &&
                         ((st_q == ST_FLAG) || (st_q == ST_DATA && !last_q));
        take           = in_ready && in_valid;
    end

    // Bit that the current state puts on the line in a normal slot.
    always_comb begin
        case (st_q)
            ST_FLAG:  cur_bit = FLAG_BYTE[idx_q[2:0]];
            ST_DATA:  cur_bit = shreg_q[0];
            ST_FCS:   cur_bit = shreg_q[0];
            ST_ABORT: cur_bit = 1'b1;
        endcase
    end

    hdlc_tx_crc #(
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY_R),
        .PRESET (CRC_PRESET)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (take && (st_q == ST_FLAG)),
        .step    (sent_frame_bit && (st_q == ST_DATA)),
        .din     (shreg_q[0]),
        .crc_upd (crc_upd)
    );

    hdlc_tx_zero_ins #(
        .RUN_LEN (RUN_LEN)
    ) u_zins (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_bit (sent_frame_bit),
        .bit_val   (shreg_q[0]),
        .clr       (bit_en && !sent_frame_bit),
        .stuff_due (stuff_due)
    );

    // Abort latch: keep a request until the next frame bit slot takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) abort_pend_q <= 1'b0;
        else        abort_pend_q <= in_frame && !abort_now && (abort_pend_q || abort_req);
    end

    // Main sequencer: line bit, state, bit index, shift register, underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_FLAG;
            idx_q    <= '0;
            shreg_q  <= '0;
            last_q   <= 1'b0;
            tx_bit   <= 1'b1;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (abort_now) begin
                tx_bit <= 1'b1;
                st_q   <= ST_ABORT;
                idx_q  <= IDX_W'(1);
            end else if (stuff_now) begin
                tx_bit <= 1'b0;
            end else if (bit_en) begin
                tx_bit <= cur_bit;
                case (st_q)
                    ST_FLAG: begin
                        if (byte_end) begin
                            idx_q <= '0;
                            if (take) begin
                                shreg_q <= {{(CRC_W - BYTE_W){1'b0}}, in_data};
                                last_q  <= in_last;
                                st_q    <= ST_DATA;
                            end
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                    ST_DATA: begin
                        shreg_q <= {1'b0, shreg_q[CRC_W-1:1]};
                        if (byte_end) begin
                            idx_q <= '0;
                            if (last_q) begin
                                if (fcs_inhibit) begin
                                    st_q <= ST_FLAG;
                                end else begin
                                    st_q    <= ST_FCS;
                                    shreg_q <= ~crc_upd;
                                end
                            end else if (take) begin
                                shreg_q <= {{(CRC_W - BYTE_W){1'b0}}, in_data};
                                last_q  <= in_last;
                            end else begin
                                st_q     <= ST_ABORT;
                                underrun <= 1'b1;
                            end
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                    ST_FCS: begin
                        shreg_q <= {1'b0, shreg_q[CRC_W-1:1]};
                        if (idx_q == IDX_W'(CRC_W - 1)) begin
                            st_q  <= ST_FLAG;
                            idx_q <= '0;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                    ST_ABORT: begin
                        if (idx_q == IDX_W'(ABORT_LEN - 1)) begin
                            st_q  <= ST_FLAG;
                            idx_q <= '0;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                endcase
            end
        end
    end
endmodule

// Module: property checker for hdlc_frame_tx, attached by bind below.
// Assumes it sees the top's sequencer state, bit index and insert-due flag.
module hdlc_frame_tx_chk
    import hdlc_tx_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             abort_req,
    input logic             in_ready,
    input logic             tx_bit,
    input logic             underrun,
    input tx_state_e        st,
    input logic [IDX_W-1:0] idx,
    input logic             stuff_due,
    input logic             abort_pend
);
    // R3: an insert slot that no abort preempts puts a zero on the line.
    assert_zero_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && stuff_due && st != ST_ABORT && !abort_pend &&
         !(abort_req && (st == ST_DATA || st == ST_FCS))) |=> !tx_bit);

    // R1: a flag slot sends the flag octet bit chosen by the index.
    assert_flag_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && st == ST_FLAG && !stuff_due) |=> (tx_bit == FLAG_BYTE[$past(idx[2:0])]));

    // R7: every slot in the abort state sends a one.
    assert_abort_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && st == ST_ABORT) |=> tx_bit);

    // R9: the underrun pulse comes with the switch to the abort run and lasts one cycle.
    assert_underrun_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (st == ST_ABORT));
    assert_underrun_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

    // R10: the line holds between enabled bits; ready only in enabled cycles.
    assert_line_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));
    assert_ready_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> bit_en);
endmodule

bind hdlc_frame_tx hdlc_frame_tx_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .abort_req  (abort_req),
    .in_ready   (in_ready),
    .tx_bit     (tx_bit),
    .underrun   (underrun),
    .st         (st_q),
    .idx        (idx_q),
    .stuff_due  (stuff_due),
    .abort_pend (abort_pend_q)
);

// File: tb/hdlc_frame_tx_tb.sv
`timescale 1ns/1ps
// Bench: the driver pushes expected frames and aborts into a scoreboard.
// The monitor decodes the serial line on its own and pops and compares.
module hdlc_frame_tx_tb;
    logic clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic       rst_n = 1'b0, bit_en = 1'b0, fcs_inhibit = 1'b0, abort_req = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0, in_last = 1'b0;
    logic       in_ready, tx_bit, underrun;

    hdlc_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fcs_inhibit(fcs_inhibit),
        .abort_req(abort_req), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .tx_bit(tx_bit), .underrun(underrun)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Bit enable: one slot every en_div cycles.
    int en_div = 1, en_cnt = 0;
    logic en_prev = 1'b0;
    always @(posedge clk) begin
        en_cnt  <= (en_cnt + 1 >= en_div) ? 0 : en_cnt + 1;
        bit_en  <= (en_cnt == 0);
        en_prev <= bit_en & rst_n;
    end

    // Scoreboard: kind 0 = frame with FCS, 1 = frame without FCS, 2 = abort.
    int         exp_kind[$];
    string      exp_tag[$];
    int         exp_len[$];
    logic [7:0] exp_data[$];
    logic [7:0] tx_bytes[$];
    int pushed = 0, done = 0;

    // Monitor state.
    bit         rxq[$];
    int         ones = 0;
    bit         hunting = 1'b1;
    int         raw_n = 0;
    logic [15:0] raw_first = '0;
    int         stuffed_seen = 0, aborts_seen = 0, hold_viol = 0, un_cnt = 0;
    logic       last_line = 1'b1;

    function automatic logic [15:0] crc_run(input logic [7:0] q[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (q[i]) for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = c[0] ^ q[i][k];
            c  = c >> 1;
            if (fb) c = c ^ 16'h8408;
        end
        return c;
    endfunction

    task automatic on_frame();
        logic [7:0] got[$];
        logic [7:0] want[$];
        int nb, kind, n, mism, cmp_len;
        string tag;
        if (rxq.size() % 8 != 0) begin
            chk(0, "R3", "frame bit count not a multiple of 8", rxq.size(), 0);
            return;
        end
        nb = rxq.size() / 8;
        for (int i = 0; i < nb; i++) begin
            logic [7:0] v;
            for (int k = 0; k < 8; k++) v[k] = rxq[i*8 + k];
            got.push_back(v);
        end
        if (exp_kind.size() == 0) begin
            chk(0, "R2", "unexpected frame, bytes", nb, 0);
            return;
        end
        kind = exp_kind.pop_front(); tag = exp_tag.pop_front(); n = exp_len.pop_front();
        for (int i = 0; i < n; i++) want.push_back(exp_data.pop_front());
        done++;
        if (kind == 2) begin
            chk(0, tag, "frame seen where abort expected, bytes", nb, 0);
            return;
        end
        cmp_len = (kind == 0) ? nb - 2 : nb;
        chk(cmp_len == n, tag, "data length", cmp_len, n);
        mism = -1;
        for (int i = 0; i < n && i < cmp_len; i++) if (got[i] != want[i]) mism = i;
        chk(mism < 0, tag, "first bad byte index", mism, -1);
        if (kind == 0)
            chk(nb >= 2 && crc_run(got) == 16'hF0B8, "R4", "FCS residue", crc_run(got), 16'hF0B8);
        else
            chk(crc_run(got) == crc_run(want), "R5", "inhibited frame carries extra bytes", nb, n);
    endtask

    task automatic on_abort();
        int kind, n;
        string tag;
        aborts_seen++;
        rxq.delete();
        hunting = 1'b1;
        if (exp_kind.size() == 0) begin
            chk(0, "R8", "unexpected abort run", 1, 0);
            return;
        end
        kind = exp_kind.pop_front(); tag = exp_tag.pop_front(); n = exp_len.pop_front();
        for (int i = 0; i < n; i++) void'(exp_data.pop_front());
        done++;
        chk(kind == 2, tag, "abort run seen, expected kind", 2, kind);
    endtask

    // Monitor: decode the line after each enabled edge; check hold otherwise.
    always @(negedge clk) begin
        if (rst_n && !en_prev && tx_bit != last_line) hold_viol++;
        if (underrun) un_cnt++;
        if (en_prev) begin
            logic b;
            b = tx_bit;
            if (raw_n < 16) begin raw_first[raw_n] = b; raw_n++; end
            if (b) begin
                ones++;
                rxq.push_back(1'b1);
                if (ones == 7) on_abort();
            end else begin
                if (ones == 5) stuffed_seen++;
                else if (ones == 6) begin
                    repeat (7) void'(rxq.pop_back());
                    if (!hunting && rxq.size() > 0) on_frame();
                    rxq.delete();
                    hunting = 1'b0;
                end else rxq.push_back(1'b0);
                ones = 0;
            end
        end
        last_line = tx_bit;
    end

    task automatic expect_item(input int kind, input string tag);
        exp_kind.push_back(kind); exp_tag.push_back(tag);
        exp_len.push_back(tx_bytes.size());
        foreach (tx_bytes[i]) exp_data.push_back(tx_bytes[i]);
        pushed++;
    endtask

    // Offer n bytes of tx_bytes; mark the last one if end_it.
    task automatic feed(input int n, input bit end_it);
        for (int i = 0; i < n; i++) begin
            in_data = tx_bytes[i]; in_last = end_it && (i == n - 1); in_valid = 1'b1;
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic wait_done();
        while (done < pushed) @(negedge clk);
    endtask

    task automatic wait_bits(input int n);
        for (int i = 0; i < n; i++) do @(negedge clk); while (!en_prev);
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
    endtask

    task automatic send_frame(input bit inh, input string tag);
        expect_item(inh ? 1 : 0, tag);
        fcs_inhibit = inh;
        feed(tx_bytes.size(), 1'b1);
        wait_done();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R10", "watchdog expired, items done", done, pushed);
        summary();
        $finish;
    end

    initial begin
        int st0, a0, u0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(tx_bit == 1'b1, "R1", "reset tx_bit", tx_bit, 1);
        chk(in_ready == 1'b0, "R1", "reset in_ready", in_ready, 0);
        chk(underrun == 1'b0, "R1", "reset underrun", underrun, 0);
        rst_n = 1'b1;
        wait_bits(24);
        chk(raw_first == 16'h7E7E, "R1", "first 16 idle bits", raw_first, 16'h7E7E);

        tx_bytes = '{8'h01, 8'h02, 8'h03, 8'h55};
        send_frame(1'b0, "R2");

        st0 = stuffed_seen;
        tx_bytes = '{8'hFF, 8'hFF, 8'h7E, 8'h3E, 8'hF8, 8'h1F};
        send_frame(1'b0, "R3");
        chk(stuffed_seen > st0, "R3", "inserted zeros seen", stuffed_seen - st0, 1);

        tx_bytes = '{8'hA5, 8'h5A, 8'hFF};
        send_frame(1'b1, "R5");

        en_div = 3;
        tx_bytes = '{8'h7E};
        send_frame(1'b0, "R6");
        tx_bytes = '{8'hFF};
        send_frame(1'b1, "R6");
        tx_bytes.delete();
        for (int i = 0; i < 20; i++) tx_bytes.push_back(8'(i * 37 + 5));
        send_frame(1'b0, "R2");
        en_div = 1;

        // Abort during data bytes.
        u0 = un_cnt;
        tx_bytes = '{8'h00, 8'h00};
        expect_item(2, "R7");
        feed(2, 1'b0);
        pulse_abort();
        wait_done();
        chk(un_cnt == u0, "R7", "no underrun on requested abort", un_cnt - u0, 0);
        tx_bytes = '{8'h11, 8'h22};
        send_frame(1'b0, "R7");

        // Abort during the FCS.
        tx_bytes = '{8'h00, 8'h00};
        expect_item(2, "R7");
        fcs_inhibit = 1'b0;
        feed(2, 1'b1);
        wait_bits(11);
        pulse_abort();
        wait_done();

        // Underrun: frame left unfinished.
        u0 = un_cnt;
        tx_bytes = '{8'h33, 8'h44};
        expect_item(2, "R9");
        feed(2, 1'b0);
        wait_done();
        wait_bits(10);
        chk(un_cnt == u0 + 1, "R9", "underrun pulses", un_cnt - u0, 1);

        // Abort request while idle is ignored.
        a0 = aborts_seen;
        wait_bits(4);
        pulse_abort();
        wait_bits(40);
        chk(aborts_seen == a0, "R8", "abort runs after idle request", aborts_seen - a0, 0);
        chk(!hunting, "R8", "monitor still locked to flags", hunting, 0);
        tx_bytes = '{8'hC3, 8'h3C};
        send_frame(1'b0, "R8");

        wait_bits(20);
        chk(hold_viol == 0, "R10", "line changes without bit_en", hold_viol, 0);
        chk(exp_kind.size() == 0, "R2", "items left in scoreboard", exp_kind.size(), 0);
        summary();
        $finish;
    end
endmodule